// File: doc/BRIEF.md
# Serial Control Word Decoder

This block receives 16-bit control words over a three-wire serial port: an active-low frame enable, a serial clock and one data line. Both serial lines are sampled in the system clock domain. A word is taken on the sixteenth falling serial-clock edge of a frame and decoded. Data-write commands build 16-bit register halves in two steps. A deferral command first parks a low byte in a holding byte. A write command then supplies the high byte and commits the pair to a phase register or to one half of a frequency register.

The block stores four 12-bit phase registers and two 32-bit frequency registers. Each frequency register is split into an upper and a lower 16-bit half, and the two halves are written separately. The block also keeps the phase-select and frequency-select bits, the select-source flag, the sync flag, the sleep flag and the accumulator-reset flag, plus a one-cycle clear pulse. Every committed data write also appears as a one-cycle strobe carrying the destination address and the 16-bit value. Downstream logic can use that strobe to move the value into another clock domain.

Top module: `scw_ctrl_decoder`

## Requirements
- R1: A word is shifted in MSB first, one bit per falling `sclk` edge while `frame_n` is low. It is acted on only at the 16th such edge. Further falling edges in the same frame are ignored until `frame_n` returns high.
- R2: If `frame_n` goes high before 16 falling edges, the partial word is dropped and nothing in the block changes.
- R3: Opcode 0001 (phase defer) and opcode 0011 (frequency defer) load D7:D0 into one shared holding byte. They write no register and raise no strobe.
- R4: Opcode 0000 writes phase register D10:D9 with the low 12 bits of {D7:D0, holding byte}. The upper 4 bits of that value are dropped.
- R5: Opcode 0010 writes {D7:D0, holding byte} into frequency register D10, upper half when D9=1 and lower half when D9=0. The other half is left unchanged.
- R6: Each 16-bit write raises `wr_stb` for exactly one cycle. On that cycle `wr_is_freq` is 1 for frequency writes, `wr_addr` carries D11:D8 and `wr_data` carries the 16-bit value.
- R7: Opcode 0110 sets the phase-select bits from D10:D9. Opcode 0111 sets the frequency-select bit from D11. Opcode 0101 sets all three select bits in one word.
- R8: When the select-source flag is 0, `sel_phase` and `sel_freq` follow `psel_pin` and `fsel_pin`. When it is 1, they follow the stored select bits.
- R9: A word with D15:D14 = 10 sets the sync flag from D13 and the select-source flag from D12.
- R10: A word with D15:D14 = 11 sets sleep from D13 and accumulator reset from D12. If D11 = 1, it also clears the sync and select-source flags and raises `clr_pulse` for exactly one cycle.
- R11: Opcode 0100 (reserved) changes nothing and raises no strobe.
- R12: After reset, all registers, flags and the holding byte are zero, and the selects follow the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low serial frame enable |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| sdata | input | 1 | Serial data, MSB first |
| psel_pin | input | 2 | Phase select from pins |
| fsel_pin | input | 1 | Frequency select from pin |
| phase_regs | output | 48 | Four 12-bit phase registers; register i at bits 12i+11:12i |
| freq_regs | output | 64 | Two 32-bit frequency registers; register i at bits 32i+31:32i |
| sel_phase | output | 2 | Effective phase register select |
| sel_freq | output | 1 | Effective frequency register select |
| sync_en | output | 1 | Sync flag |
| selsrc | output | 1 | Select-source flag (1 = stored bits) |
| sleep | output | 1 | Sleep flag |
| acc_reset | output | 1 | Accumulator reset flag |
| clr_pulse | output | 1 | One-cycle clear pulse |
| wr_stb | output | 1 | One-cycle strobe for a committed 16-bit write |
| wr_is_freq | output | 1 | Strobed write targets a frequency half |
| wr_addr | output | 4 | Destination address, D11:D8 of the write word |
| wr_data | output | 16 | Value written |

## Verification
The stimulus mixes byte deferrals with writes to different phase indices and to both frequency halves. This shows whether the holding byte lands in the low byte and whether the other half is kept. A phase write with a non-zero upper nibble checks that the nibble is dropped. The holding byte is loaded by a phase-defer command and then used by a frequency write, which shows that the holding byte is shared. Select-bit commands are issued once while the select-source flag is 0 and once while it is 1, so the pin path and the bit path are told apart. Frames are also sent with 10 and with 18 falling edges, which separates the early-end discard from capture at the sixteenth edge.

// File: rtl/scw_pkg.sv
package scw_pkg;
    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int PHASE_W  = 12;
    localparam int N_PHASE  = 4;
    localparam int FREQ_W   = 32;
    localparam int N_FREQ   = 2;
    localparam int HALF_W   = FREQ_W / 2;
    localparam int N_HALF   = 2 * N_FREQ;
    localparam int PIDX_W   = $clog2(N_PHASE);
    localparam int FIDX_W   = $clog2(N_FREQ);
    localparam int HIDX_W   = $clog2(N_HALF);
    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam int ADDR_W   = 4;
    localparam int ADDR_LSB = 8;
    localparam int IDX_LSB  = 1;
    localparam int PSEL_LSB = 9;
    localparam int FSEL_BIT = 11;
    localparam int HI_BIT   = 13;
    localparam int MID_BIT  = 12;
    localparam int CLR_BIT  = 11;

    typedef enum logic [3:0] {
        OP_PH_WR    = 4'b0000,
        OP_PH_DEF   = 4'b0001,
        OP_FR_WR    = 4'b0010,
        OP_FR_DEF   = 4'b0011,
        OP_TEST     = 4'b0100,
        OP_SEL_BOTH = 4'b0101,
        OP_SEL_PH   = 4'b0110,
        OP_SEL_FR   = 4'b0111
    } op_e;
endpackage

// File: rtl/scw_serial_rx.sv
module scw_serial_rx
    import scw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              sclk,
    input  logic              sdata,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shift;
        logic              vld;
    } rx_state_t;

    rx_state_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.sclk_prev = sclk;
        s_d.vld       = 1'b0;
        if (frame_n) begin
            s_d.cnt = '0;
        end else if (s_q.sclk_prev && !sclk && (s_q.cnt < CNT_W'(WORD_W))) begin
            s_d.shift = {s_q.shift[WORD_W-2:0], sdata};
            s_d.cnt   = s_q.cnt + 1'b1;
            if (s_q.cnt == CNT_W'(WORD_W - 1)) begin
                s_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_vld = s_q.vld;
    assign word     = s_q.shift;
endmodule

// File: rtl/scw_cmd_decode.sv
module scw_cmd_decode
    import scw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    output logic              wr_stb,
    output logic              wr_is_freq,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [PIDX_W-1:0] psel_bits,
    output logic [FIDX_W-1:0] fsel_bits,
    output logic              sync_en,
    output logic              selsrc,
    output logic              sleep,
    output logic              acc_reset,
    output logic              clr_pulse
);
    typedef struct packed {
        logic [BYTE_W-1:0] hold;
        logic              sync;
        logic              src;
        logic              slp;
        logic              arst;
        logic              clr;
        logic [PIDX_W-1:0] psel;
        logic [FIDX_W-1:0] fsel;
        logic              stb;
        logic              is_freq;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } dec_state_t;

    dec_state_t c_d, c_q;
    op_e        op;

    assign op = op_e'(word[WORD_W-1 -: 4]);

    always_comb begin
        c_d     = c_q;
        c_d.stb = 1'b0;
        c_d.clr = 1'b0;
        if (word_vld) begin
            if (word[WORD_W-1]) begin
                if (!word[WORD_W-2]) begin
                    c_d.sync = word[HI_BIT];
                    c_d.src  = word[MID_BIT];
                end else begin
                    c_d.slp  = word[HI_BIT];
                    c_d.arst = word[MID_BIT];
                    if (word[CLR_BIT]) begin
                        c_d.clr  = 1'b1;
                        c_d.sync = 1'b0;
                        c_d.src  = 1'b0;
                    end
                end
            end else begin
                unique case (op)
                    OP_PH_DEF, OP_FR_DEF: begin
                        c_d.hold = word[BYTE_W-1:0];
                    end
                    OP_PH_WR, OP_FR_WR: begin
                        c_d.stb     = 1'b1;
                        c_d.is_freq = (op == OP_FR_WR);
                        c_d.addr    = word[ADDR_LSB +: ADDR_W];
                        c_d.data    = {word[BYTE_W-1:0], c_q.hold};
                    end
                    OP_SEL_PH: begin
                        c_d.psel = word[PSEL_LSB +: PIDX_W];
                    end
                    OP_SEL_FR: begin
                        c_d.fsel = word[FSEL_BIT -: FIDX_W];
                    end
                    OP_SEL_BOTH: begin
                        c_d.psel = word[PSEL_LSB +: PIDX_W];
                        c_d.fsel = word[FSEL_BIT -: FIDX_W];
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign wr_stb     = c_q.stb;
    assign wr_is_freq = c_q.is_freq;
    assign wr_addr    = c_q.addr;
    assign wr_data    = c_q.data;
    assign psel_bits  = c_q.psel;
    assign fsel_bits  = c_q.fsel;
    assign sync_en    = c_q.sync;
    assign selsrc     = c_q.src;
    assign sleep      = c_q.slp;
    assign acc_reset  = c_q.arst;
    assign clr_pulse  = c_q.clr;
endmodule

// File: rtl/scw_reg_bank.sv
module scw_reg_bank
    import scw_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_stb,
    input  logic                         wr_is_freq,
    input  logic [HIDX_W-1:0]            wr_idx,
    input  logic [WORD_W-1:0]            wr_data,
    output logic [N_PHASE*PHASE_W-1:0]   phase_regs,
    output logic [N_FREQ*FREQ_W-1:0]     freq_regs
);
    typedef struct packed {
        logic [N_PHASE-1:0][PHASE_W-1:0] ph;
        logic [N_HALF-1:0][HALF_W-1:0]   fh;
    } bank_t;

    bank_t             b_d, b_q;
    logic [N_PHASE-1:0] ph_we;
    logic [N_HALF-1:0]  fh_we;

    for (genvar i = 0; i < N_PHASE; i++) begin : g_ph_we
        assign ph_we[i] = wr_stb && !wr_is_freq
                          && (wr_idx[PIDX_W-1:0] == PIDX_W'(i));
    end

    for (genvar j = 0; j < N_HALF; j++) begin : g_fh_we
        assign fh_we[j] = wr_stb && wr_is_freq
                          && (wr_idx == HIDX_W'(j));
    end

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < N_PHASE; i++) begin
            if (ph_we[i]) begin
                b_d.ph[i] = wr_data[PHASE_W-1:0];
            end
        end
        for (int j = 0; j < N_HALF; j++) begin
            if (fh_we[j]) begin
                b_d.fh[j] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign phase_regs = b_q.ph;
    assign freq_regs  = b_q.fh;
endmodule

// File: rtl/scw_ctrl_decoder.sv
module scw_ctrl_decoder
    import scw_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_n,
    input  logic                       sclk,
    input  logic                       sdata,
    input  logic [PIDX_W-1:0]          psel_pin,
    input  logic [FIDX_W-1:0]          fsel_pin,
    output logic [N_PHASE*PHASE_W-1:0] phase_regs,
    output logic [N_FREQ*FREQ_W-1:0]   freq_regs,
    output logic [PIDX_W-1:0]          sel_phase,
    output logic [FIDX_W-1:0]          sel_freq,
    output logic                       sync_en,
    output logic                       selsrc,
    output logic                       sleep,
    output logic                       acc_reset,
    output logic                       clr_pulse,
    output logic                       wr_stb,
    output logic                       wr_is_freq,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [WORD_W-1:0]          wr_data
);
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic [PIDX_W-1:0] psel_bits;
    logic [FIDX_W-1:0] fsel_bits;

    scw_serial_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .sclk     (sclk),
        .sdata    (sdata),
        .word_vld (word_vld),
        .word     (word)
    );

    scw_cmd_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_vld   (word_vld),
        .word       (word),
        .wr_stb     (wr_stb),
        .wr_is_freq (wr_is_freq),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .psel_bits  (psel_bits),
        .fsel_bits  (fsel_bits),
        .sync_en    (sync_en),
        .selsrc     (selsrc),
        .sleep      (sleep),
        .acc_reset  (acc_reset),
        .clr_pulse  (clr_pulse)
    );

    scw_reg_bank u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .wr_is_freq (wr_is_freq),
        .wr_idx     (wr_addr[IDX_LSB +: HIDX_W]),
        .wr_data    (wr_data),
        .phase_regs (phase_regs),
        .freq_regs  (freq_regs)
    );

    assign sel_phase = selsrc ? psel_bits : psel_pin;
    assign sel_freq  = selsrc ? fsel_bits : fsel_pin;
endmodule

// File: rtl/scw_ctrl_decoder_chk.sv
module scw_ctrl_decoder_chk
    import scw_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       frame_n,
    input logic                       wr_stb,
    input logic                       wr_is_freq,
    input logic                       clr_pulse,
    input logic                       sync_en,
    input logic                       selsrc,
    input logic [N_PHASE*PHASE_W-1:0] phase_regs,
    input logic [N_FREQ*FREQ_W-1:0]   freq_regs
);
    // R6
    wr_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R1
    wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(frame_n, 2) == 1'b0));

    // R10
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !clr_pulse);

    // R10
    clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |-> (!sync_en && !selsrc));

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(wr_stb) && !$past(wr_is_freq)) |-> $stable(phase_regs));

    // R5
    freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(wr_stb) && $past(wr_is_freq)) |-> $stable(freq_regs));
endmodule

bind scw_ctrl_decoder scw_ctrl_decoder_chk u_chk (.*);

// File: tb/scw_ctrl_decoder_tb.sv
module scw_ctrl_decoder_tb;
    import scw_pkg::*;

    localparam int CLK_P = 10;

    localparam logic [2:0] K_NONE = 3'd0;
    localparam logic [2:0] K_PH   = 3'd1;
    localparam logic [2:0] K_FR   = 3'd2;
    localparam logic [2:0] K_SP   = 3'd3;
    localparam logic [2:0] K_SF   = 3'd4;
    localparam logic [2:0] K_CT   = 3'd5;

    typedef struct packed {
        logic [15:0] word;
        logic [2:0]  kind;
        logic [1:0]  idx;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int N_VEC = 20;
    localparam vec_t VECS [N_VEC] = '{
        '{16'h1134, K_PH,   2'd0, 32'h0000_0000, 4'd3},  // R3 defer only
        '{16'h02AB, K_PH,   2'd1, 32'h0000_0B34, 4'd4},  // R4
        '{16'h3178, K_FR,   2'd0, 32'h0000_0000, 4'd3},  // R3
        '{16'h2656, K_FR,   2'd1, 32'h5678_0000, 4'd5},  // R5 upper
        '{16'h3199, K_NONE, 2'd0, 32'h0000_0000, 4'd3},
        '{16'h2411, K_FR,   2'd1, 32'h5678_1199, 4'd5},  // R5 lower
        '{16'h7800, K_SF,   2'd0, 32'h0000_0000, 4'd8},  // R8 pins
        '{16'h6200, K_SP,   2'd0, 32'h0000_0002, 4'd8},  // R8 pins
        '{16'h9000, K_SP,   2'd0, 32'h0000_0001, 4'd7},  // R7 R9
        '{16'h9000, K_SF,   2'd0, 32'h0000_0001, 4'd7},  // R7
        '{16'h5400, K_SP,   2'd0, 32'h0000_0002, 4'd7},  // R7 combined
        '{16'h5400, K_SF,   2'd0, 32'h0000_0000, 4'd7},  // R7
        '{16'hB000, K_CT,   2'd0, 32'h0000_0003, 4'd9},  // R9
        '{16'hF000, K_CT,   2'd0, 32'h0000_000F, 4'd10}, // R10
        '{16'hC800, K_CT,   2'd0, 32'h0000_0000, 4'd10}, // R10 clear
        '{16'h4FFF, K_PH,   2'd1, 32'h0000_0B34, 4'd11}, // R11
        '{16'h10CD, K_NONE, 2'd0, 32'h0000_0000, 4'd3},
        '{16'h20AB, K_FR,   2'd0, 32'h0000_ABCD, 4'd5},  // R5, shared byte R3
        '{16'h1121, K_NONE, 2'd0, 32'h0000_0000, 4'd3},
        '{16'h06F3, K_PH,   2'd3, 32'h0000_0321, 4'd4}   // R4 nibble dropped
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdata = 1'b0;
    logic [1:0]  psel_pin = 2'b10;
    logic [0:0]  fsel_pin = 1'b0;
    logic [47:0] phase_regs;
    logic [63:0] freq_regs;
    logic [1:0]  sel_phase;
    logic [0:0]  sel_freq;
    logic        sync_en, selsrc, sleep, acc_reset, clr_pulse;
    logic        wr_stb, wr_is_freq;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;

    int          n_chk = 0;
    int          n_err = 0;
    int          stb_cnt = 0;
    int          clr_cnt = 0;
    logic [3:0]  last_addr = '0;
    logic [15:0] last_data = '0;
    logic        last_freq = 1'b0;
    int          base;

    always #(CLK_P / 2) clk = ~clk;

    scw_ctrl_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .sclk       (sclk),
        .sdata      (sdata),
        .psel_pin   (psel_pin),
        .fsel_pin   (fsel_pin),
        .phase_regs (phase_regs),
        .freq_regs  (freq_regs),
        .sel_phase  (sel_phase),
        .sel_freq   (sel_freq),
        .sync_en    (sync_en),
        .selsrc     (selsrc),
        .sleep      (sleep),
        .acc_reset  (acc_reset),
        .clr_pulse  (clr_pulse),
        .wr_stb     (wr_stb),
        .wr_is_freq (wr_is_freq),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb) begin
                stb_cnt++;
                last_addr = wr_addr;
                last_data = wr_data;
                last_freq = wr_is_freq;
            end
            if (clr_pulse) clr_cnt++;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w, input int nfall);
        logic [15:0] sh;
        sh = w;
        @(negedge clk);
        frame_n = 1'b0;
        for (int i = 0; i < nfall; i++) begin
            @(negedge clk);
            sdata = sh[15];
            sh    = sh << 1;
            sclk  = 1'b1;
            repeat (2) @(negedge clk);
            sclk  = 1'b0;
            repeat (2) @(negedge clk);
        end
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        frame_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12 reset state
        chk("R12", "phase_regs", 32'(phase_regs == '0), 32'd1);
        chk("R12", "freq_regs", 32'(freq_regs == '0), 32'd1);
        chk("R12", "flags", {28'd0, sleep, acc_reset, sync_en, selsrc}, 32'd0);
        chk("R12", "sel_phase from pins", {30'd0, sel_phase}, 32'd2);

        for (int v = 0; v < N_VEC; v++) begin
            vec_t e;
            e = VECS[v];
            send(e.word, 16);
            case (e.kind)
                K_PH: chk($sformatf("R%0d", e.req), "phase reg",
                          {20'd0, phase_regs[e.idx*12 +: 12]}, e.exp);
                K_FR: chk($sformatf("R%0d", e.req), "freq reg",
                          freq_regs[e.idx[0]*32 +: 32], e.exp);
                K_SP: chk($sformatf("R%0d", e.req), "sel_phase",
                          {30'd0, sel_phase}, e.exp);
                K_SF: chk($sformatf("R%0d", e.req), "sel_freq",
                          {31'd0, sel_freq}, e.exp);
                K_CT: chk($sformatf("R%0d", e.req), "flags",
                          {28'd0, sleep, acc_reset, sync_en, selsrc}, e.exp);
                default: ;
            endcase
        end

        // R10 exactly one clear pulse seen
        chk("R10", "clr pulse count", 32'(clr_cnt), 32'd1);

        // R2 short frame discarded
        base = stb_cnt;
        send(16'h06AA, 10);
        chk("R2", "phase3 after short frame", {20'd0, phase_regs[36 +: 12]}, 32'h321);
        chk("R2", "no strobe on short frame", 32'(stb_cnt - base), 32'd0);

        // R1 extra edges after 16th ignored; R6 strobe contents
        base = stb_cnt;
        send(16'h0055, 18);
        chk("R1", "phase0 with extra edges", {20'd0, phase_regs[0 +: 12]}, 32'h521);
        chk("R6", "one strobe", 32'(stb_cnt - base), 32'd1);
        chk("R6", "wr_addr", {28'd0, last_addr}, 32'h0);
        chk("R6", "wr_data", {16'd0, last_data}, 32'h5521);
        chk("R6", "wr_is_freq", {31'd0, last_freq}, 32'd0);

        // R3 defer raises no strobe
        base = stb_cnt;
        send(16'h3100, 16);
        chk("R3", "no strobe on defer", 32'(stb_cnt - base), 32'd0);

        // R6 frequency strobe
        base = stb_cnt;
        send(16'h2212, 16);
        chk("R6", "freq strobe flag", {31'd0, last_freq}, 32'd1);
        chk("R6", "freq strobe addr", {28'd0, last_addr}, 32'h2);
        chk("R5", "freq0 upper", freq_regs[0 +: 32], 32'h1200_ABCD);

        // R11 reserved opcode
        base = stb_cnt;
        send(16'h4A5A, 16);
        chk("R11", "no strobe on reserved", 32'(stb_cnt - base), 32'd0);
        chk("R11", "freq1 unchanged", freq_regs[32 +: 32], 32'h5678_1199);

        finish_run();
    end
endmodule